// File: doc/BRIEF.md
# CPU clock and standby controller

This block produces the CPU clock enable for a small processor core. The enable is a one-cycle pulse per machine cycle. It counts periods of one of two oscillators, both delivered as tick pulses in the block's own clock domain. The fast main source can run at one of four machine-cycle lengths. The slow subsystem source runs at a single fixed length. A change of source or rate waits for the end of the current machine cycle, so no CPU cycle is ever cut short.

The block also generates a bus of peripheral clock taps, which are power-of-two enable pulses taken from a divider driven by the main oscillator. It holds the two standby states:

- **Halt** gates only the CPU enable. The peripheral taps keep running.
- **Stop** also raises the oscillator-stop output, and the block then ignores main ticks.

A release from the interrupt controller ends either standby state. Leaving stop passes through a wait state, and the CPU enable stays off until the interval timer signals that the oscillator has settled.

Top module: `cpuclk_ctrl`

## Requirements
- R1: With the main source (src_sel=0) the machine cycle is 4, 8, 16 or 64 main ticks for rate codes 0, 1, 2 and 3. cpu_ce pulses for one clock, one clock after the tick that completes a cycle.
- R2: With the subsystem source (src_sel=1) a machine cycle is 4 sub_tick pulses, and main ticks do not advance it.
- R3: rate_sel and src_sel are taken only on the tick that ends a machine cycle. A change at any other time does not alter the length of the cycle in progress.
- R4: halt_req sets the halt state. irq_release clears it and wins when both arrive in the same cycle. While halted, cpu_ce stays low.
- R5: During halt the peripheral taps and the machine-cycle counting continue unchanged.
- R6: stop_req sets osc_stop from the next clock. While it is set, main ticks are ignored: all taps are zero, main-source cycle counting freezes and cpu_ce stays low.
- R7: irq_release while stopped clears osc_stop and enters a wait state. cpu_ce stays low until bt_wait_release arrives. bt_wait_release outside the wait state has no effect.
- R8: periph_tap bit k pulses once every 2^k accepted main ticks (k = 0 to 12). Bit 0 follows every tick. Each bit is registered one clock after its tick.
- R9: Synchronous reset selects the main source at rate code 3 (64 ticks), clears halt, stop and wait, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | One pulse per main oscillator period |
| sub_tick | input | 1 | One pulse per subsystem oscillator period |
| rate_sel | input | 2 | Main machine-cycle length code (0:4, 1:8, 2:16, 3:64) |
| src_sel | input | 1 | Source select, 0 main, 1 subsystem |
| halt_req | input | 1 | Enter halt |
| stop_req | input | 1 | Enter stop |
| irq_release | input | 1 | Standby release from interrupt controller |
| bt_wait_release | input | 1 | Oscillator-settled signal from interval timer |
| cpu_ce | output | 1 | CPU clock enable, one pulse per machine cycle |
| periph_tap | output | 13 | Divide-by-2^k main tick enables, k = 0 to 12 |
| osc_stop | output | 1 | Oscillator stop request |

## Verification
Each rate code is first run with a steady main tick, so the spacing of the enable pulses isolates the cycle length of that code alone. A run on the subsystem source with sparse sub ticks shows that only those ticks count. Randomly gappy main ticks with settings that toggle every cycle separate boundary-only updating from immediate updating, because an early update would cut a cycle short. Directed halt and stop sequences follow, including simultaneous request and release, and a premature timer release during stop. They tell apart the clearing priorities, the frozen divider and the wait gate.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    localparam int CNT_W      = 7;
    localparam int SUB_CYC    = 4;
    localparam int DIV_STAGES = 12;
    localparam int TAP_W      = DIV_STAGES + 1;

    typedef enum logic [1:0] {
        RATE_D4  = 2'd0,
        RATE_D8  = 2'd1,
        RATE_D16 = 2'd2,
        RATE_D64 = 2'd3
    } rate_e;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_SUB  = 1'b1
    } src_e;

    typedef struct packed {
        rate_e rate;
        src_e  src;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{rate: RATE_D64, src: SRC_MAIN};

    function automatic logic [CNT_W-1:0] cycle_len(clk_cfg_t c);
        if (c.src == SRC_SUB) return CNT_W'(SUB_CYC);
        case (c.rate)
            RATE_D4:  return CNT_W'(4);
            RATE_D8:  return CNT_W'(8);
            RATE_D16: return CNT_W'(16);
            default:  return CNT_W'(64);
        endcase
    endfunction

endpackage

// File: rtl/cpuclk_mcycle.sv
module cpuclk_mcycle
    import cpuclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     main_pulse,
    input  logic     sub_tick,
    input  clk_cfg_t cfg_in,
    output logic     mc_end
);

    clk_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             tick;

    always_comb begin
        tick   = (cfg_q.src == SRC_SUB) ? sub_tick : main_pulse;
        lim    = cycle_len(cfg_q);
        mc_end = tick && (cnt_q == lim - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            cnt_q <= '0;
        end else if (tick) begin
            if (mc_end) begin
                cnt_q <= '0;
                cfg_q <= cfg_in;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !$past(mc_end) |-> $stable(cfg_q)) else $error("cfg changed mid-cycle"); // R3

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q < lim) else $error("cycle count out of range"); // R1

endmodule

// File: rtl/cpuclk_divchain.sv
module cpuclk_divchain
    import cpuclk_pkg::*;
#(
    parameter int STAGES = DIV_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          main_pulse,
    output logic [STAGES:0] tap
);

    logic [STAGES-1:0] div_q;
    logic [STAGES:0]   tap_n;

    for (genvar k = 0; k <= STAGES; k++) begin : g_tap
        if (k == 0) begin : g_base
            assign tap_n[k] = main_pulse;
        end else begin : g_div
            assign tap_n[k] = main_pulse & (&div_q[k-1:0]);
            AST_TAP_NESTED: assert property (@(posedge clk) disable iff (rst)
                tap[k] |-> tap[k-1]) else $error("tap nesting broken"); // R8
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            tap   <= '0;
        end else begin
            div_q <= div_q + STAGES'(main_pulse);
            tap   <= tap_n;
        end
    end

endmodule

// File: rtl/cpuclk_standby.sv
module cpuclk_standby (
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic stop_req,
    input  logic irq_release,
    input  logic bt_wait_release,
    output logic halt_q,
    output logic stop_q,
    output logic wait_q
);

    logic halt_n, stop_n, wait_n;

    always_comb begin
        halt_n = halt_q;
        stop_n = stop_q;
        wait_n = wait_q;
        if (irq_release) begin
            halt_n = 1'b0;
            stop_n = 1'b0;
        end else begin
            if (halt_req) halt_n = 1'b1;
            if (stop_req) stop_n = 1'b1;
        end
        if (bt_wait_release && wait_q) wait_n = 1'b0;
        if (irq_release && stop_q)     wait_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            stop_q <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            halt_q <= halt_n;
            stop_q <= stop_n;
            wait_q <= wait_n;
        end
    end

    AST_STOP_EXIT_WAITS: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_q) |-> wait_q) else $error("stop exit skipped wait"); // R7

    AST_WAIT_NEEDS_TIMER: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_q) |-> $past(bt_wait_release)) else $error("wait left early"); // R7

    AST_HALT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_q) |-> $past(halt_req)) else $error("spurious halt"); // R4

endmodule

// File: rtl/cpuclk_ctrl.sv
module cpuclk_ctrl
    import cpuclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             main_tick,
    input  logic             sub_tick,
    input  logic [1:0]       rate_sel,
    input  logic             src_sel,
    input  logic             halt_req,
    input  logic             stop_req,
    input  logic             irq_release,
    input  logic             bt_wait_release,
    output logic             cpu_ce,
    output logic [TAP_W-1:0] periph_tap,
    output logic             osc_stop
);

    logic     halt_q, stop_q, wait_q;
    logic     main_pulse;
    logic     mc_end;
    clk_cfg_t cfg_in;

    assign main_pulse = main_tick & ~stop_q;
    assign cfg_in     = '{rate: rate_e'(rate_sel), src: src_e'(src_sel)};
    assign osc_stop   = stop_q;

    cpuclk_standby u_standby (
        .clk             (clk),
        .rst             (rst),
        .halt_req        (halt_req),
        .stop_req        (stop_req),
        .irq_release     (irq_release),
        .bt_wait_release (bt_wait_release),
        .halt_q          (halt_q),
        .stop_q          (stop_q),
        .wait_q          (wait_q)
    );

    cpuclk_mcycle u_mcycle (
        .clk        (clk),
        .rst        (rst),
        .main_pulse (main_pulse),
        .sub_tick   (sub_tick),
        .cfg_in     (cfg_in),
        .mc_end     (mc_end)
    );

    cpuclk_divchain #(.STAGES(DIV_STAGES)) u_div (
        .clk        (clk),
        .rst        (rst),
        .main_pulse (main_pulse),
        .tap        (periph_tap)
    );

    always_ff @(posedge clk) begin
        if (rst) cpu_ce <= 1'b0;
        else     cpu_ce <= mc_end & ~halt_q & ~stop_q & ~wait_q;
    end

    AST_HALT_GATES_CE: assert property (@(posedge clk) disable iff (rst)
        (halt_q && $past(halt_q)) |-> !cpu_ce) else $error("ce during halt"); // R4

    AST_STOP_GATES_CE: assert property (@(posedge clk) disable iff (rst)
        (osc_stop && $past(osc_stop)) |-> !cpu_ce) else $error("ce during stop"); // R6

    AST_STOP_FREEZES_TAPS: assert property (@(posedge clk) disable iff (rst)
        osc_stop |=> (periph_tap == '0)) else $error("taps moving in stop"); // R6

endmodule

// File: tb/cpuclk_ctrl_test.sv
module cpuclk_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        main_tick = 1'b0, sub_tick = 1'b0;
    logic [1:0]  rate_sel = 2'd3;
    logic        src_sel = 1'b0;
    logic        halt_req = 1'b0, stop_req = 1'b0;
    logic        irq_release = 1'b0, bt_wait_release = 1'b0;
    logic        cpu_ce, osc_stop;
    logic [12:0] periph_tap;

    int vectors = 0, miscompares = 0, cycles = 0;
    string cur_req = "R9";
    bit done = 0;

    // behavioural reference state
    int  m_cnt = 0, m_rate = 3, m_src = 0, m_div = 0;
    bit  m_halt = 0, m_stop = 0, m_wait = 0;
    bit  e_ce = 0, e_osc = 0;
    bit [12:0] e_tap = '0;

    always #4 clk = ~clk;

    cpuclk_ctrl uut (
        .clk(clk), .rst(rst), .main_tick(main_tick), .sub_tick(sub_tick),
        .rate_sel(rate_sel), .src_sel(src_sel), .halt_req(halt_req),
        .stop_req(stop_req), .irq_release(irq_release),
        .bt_wait_release(bt_wait_release), .cpu_ce(cpu_ce),
        .periph_tap(periph_tap), .osc_stop(osc_stop)
    );

    function automatic int len_of(int src, int rate);
        if (src != 0) return 4;
        case (rate)
            0: return 4;
            1: return 8;
            2: return 16;
            default: return 64;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cnt = 0; m_rate = 3; m_src = 0; m_div = 0;
            m_halt = 0; m_stop = 0; m_wait = 0;
            e_ce = 0; e_osc = 0; e_tap = '0;
        end else begin
            bit em, tk, fin, nw;
            em  = main_tick && !m_stop;
            tk  = (m_src != 0) ? sub_tick : em;
            fin = tk && (m_cnt == len_of(m_src, m_rate) - 1);
            e_ce = fin && !m_halt && !m_stop && !m_wait;
            for (int k = 0; k < 13; k++)
                e_tap[k] = em && ((m_div % (1 << k)) == ((1 << k) - 1));
            if (em) m_div = (m_div + 1) % 4096;
            if (tk) begin
                if (fin) begin
                    m_cnt = 0; m_rate = int'(rate_sel); m_src = int'(src_sel);
                end else m_cnt++;
            end
            nw = m_wait;
            if (bt_wait_release && m_wait) nw = 0;
            if (irq_release && m_stop) nw = 1;
            if (irq_release) begin
                m_halt = 0; m_stop = 0;
            end else begin
                if (halt_req) m_halt = 1;
                if (stop_req) m_stop = 1;
            end
            m_wait = nw;
            e_osc = m_stop;
        end
    end

    task automatic compare();
        vectors++;
        if (cpu_ce !== e_ce) begin
            miscompares++;
            $display("FAIL %s cpu_ce actual=%b expected=%b", cur_req, cpu_ce, e_ce);
        end
        if (periph_tap !== e_tap) begin
            miscompares++;
            $display("FAIL %s periph_tap actual=%h expected=%h", cur_req, periph_tap, e_tap);
        end
        if (osc_stop !== e_osc) begin
            miscompares++;
            $display("FAIL %s osc_stop actual=%b expected=%b", cur_req, osc_stop, e_osc);
        end
    endtask

    // one cycle: check outputs at negedge, then drive next inputs
    task automatic step(input bit mt, input bit st, input bit hr, input bit sr,
                        input bit ir, input bit bw);
        @(negedge clk);
        compare();
        main_tick = mt; sub_tick = st; halt_req = hr; stop_req = sr;
        irq_release = ir; bt_wait_release = bw;
    endtask

    task automatic run_idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        cur_req = "R9";
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        run_idle(140);                       // reset rate: 64-tick cycles

        cur_req = "R1";
        for (int r = 0; r < 4; r++) begin
            rate_sel = 2'(r);
            run_idle(300);
        end

        cur_req = "R2";
        src_sel = 1'b1;
        for (int i = 0; i < 300; i++) step($urandom_range(1, 0), (i % 5) == 0, 0, 0, 0, 0);

        cur_req = "R3";
        for (int i = 0; i < 1500; i++) begin
            rate_sel = 2'($urandom_range(3, 0));
            src_sel  = ($urandom_range(7, 0) == 0);
            step($urandom_range(3, 0) != 0, $urandom_range(2, 0) == 0, 0, 0, 0, 0);
        end

        src_sel = 1'b0; rate_sel = 2'd0;
        run_idle(80);
        cur_req = "R4";
        step(1, 0, 1, 0, 0, 0);
        run_idle(40);
        cur_req = "R5";
        run_idle(60);
        cur_req = "R4";
        step(1, 0, 0, 0, 1, 0);
        run_idle(20);
        step(1, 0, 1, 0, 1, 0);              // release wins
        run_idle(20);

        cur_req = "R6";
        step(1, 0, 0, 1, 0, 0);
        run_idle(50);
        cur_req = "R7";
        step(1, 0, 0, 0, 0, 1);              // timer release while stopped: no effect
        run_idle(10);
        step(1, 0, 0, 0, 1, 0);
        run_idle(30);
        step(1, 0, 0, 0, 0, 1);
        run_idle(40);
        step(1, 0, 0, 0, 0, 1);              // outside wait: no effect
        run_idle(20);

        cur_req = "R8";
        for (int i = 0; i < 9000; i++) begin
            if ((i % 97) == 0) rate_sel = 2'($urandom_range(3, 0));
            step($urandom_range(4, 0) != 0, $urandom_range(3, 0) == 0,
                 $urandom_range(300, 0) == 0, $urandom_range(600, 0) == 0,
                 $urandom_range(150, 0) == 0, $urandom_range(100, 0) == 0);
        end
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1);
        run_idle(8200);                      // full wrap of the divider chain
        @(negedge clk);
        compare();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=%0d cycles expected=completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule